// File: doc/BRIEF.md
# Adaptive Recency/Frequency Replacement Controller

This block keeps the replacement state for a small, fully associative tag store of `ENTRIES` resident tags. The residents are split between two partitions. A recency partition takes every newly missed tag and gives up its least recently inserted entry first. A frequency partition takes tags that have proven reuse and gives up its least counted entry first. Two ghost histories keep only the tags of recent victims, one history for each partition. A later lookup that hits a ghost tag moves a target split register. That register sets how many residents the recency partition should hold.

Each lookup is a tag offered on a valid/ready request port. The block answers with a fixed latency. The answer gives the lookup class (miss, resident hit, or ghost hit and which history it hit), whether a resident was evicted and the victim tag, and the current target split. Each resident entry holds a partition flag, a recency stamp and a saturating access counter. Data storage and backing-memory traffic belong to the surrounding cache.

Top module: `arc_repl_ctrl`

## Requirements
- R1: A request is accepted when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is low in the cycle that follows, and `rsp_valid` is high for exactly one cycle, two edges after the accepting edge. `req_ready` is high again in that same cycle.
- R2: A tag that is neither resident nor in a ghost history reports `rsp_kind` = 0 (miss) and enters the recency partition with count 1. If a slot is free there is no eviction, and a miss never changes `rsp_target`.
- R3: When a miss finds all `ENTRIES` slots valid, the victim comes from the recency partition if that partition is non-empty and either holds more entries than the target or the frequency partition is empty. Otherwise the victim comes from the frequency partition. A recency victim is its oldest-inserted entry.
- R4: A resident hit reports `rsp_kind` = 1, evicts nothing and leaves `rsp_target` unchanged. A hit in the recency partition moves the entry to the frequency partition with count 2. A hit in the frequency partition adds one to its count, which saturates at 2^CNT_W−1. Both kinds of hit refresh the stamp.
- R5: A frequency-partition victim is the entry with the lowest count. When counts are equal, the entry with the older stamp goes first.
- R6: A hit in the recency ghost history reports `rsp_kind` = 2 and raises the target by one, saturating at `ENTRIES`. If the store is full, the victim is the frequency-partition choice of R5, or the oldest recency entry if the frequency partition is empty. The tag returns as a frequency-partition resident with count 2.
- R7: A hit in the frequency ghost history reports `rsp_kind` = 3 and lowers the target by one, saturating at 0. If the store is full, the victim is the oldest recency entry, or the R5 choice if the recency partition is empty. The tag returns as a frequency-partition resident with count 2.
- R8: A victim's tag goes into the history of its own partition. Each history holds at most `ENTRIES` tags, and when it is full its oldest tag is dropped first. A tag that hits a ghost history leaves that history in the same lookup.
- R9: After reset, `req_ready` is 1, `rsp_valid` is 0, `rsp_target` is 0, and no tag is resident or remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup |
| req_tag | input | TAG_W | Tag to look up |
| rsp_valid | output | 1 | Response fields valid this cycle |
| rsp_kind | output | 2 | 0 miss, 1 resident hit, 2 recency-ghost hit, 3 frequency-ghost hit |
| rsp_evict | output | 1 | A resident was evicted by this lookup |
| rsp_victim | output | TAG_W | Tag of the evicted resident (0 when none) |
| rsp_target | output | $clog2(ENTRIES+1) | Target size of the recency partition |

## Verification
Two operations can fall in the same cycle: a ghost hit removes a tag from one history, and the eviction it causes inserts a victim tag into a history. The victim may go into the same history or into the other one, and the other one may already be full. These cases are provoked by long runs of short cyclic scans and pseudo-random tags drawn from ranges a little larger than the store. Under those runs both histories stay full while ghost hits keep arriving. A bench model holds each partition and each history as an ordered queue. It predicts the class, the victim and the target of every lookup, and a wrong drop or a slot reused twice shows up as a later class or victim mismatch. A short directed sequence fills one history past capacity and then confirms which tags it still holds.

// File: rtl/arc_pkg.sv
package arc_pkg;
  typedef enum logic [1:0] {
    K_MISS = 2'd0,
    K_HIT  = 2'd1,
    K_GB1  = 2'd2,
    K_GB2  = 2'd3
  } kind_e;
endpackage

// File: rtl/arc_res_store.sv
module arc_res_store #(
  parameter int C       = 4,
  parameter int TAG_W   = 8,
  parameter int CNT_W   = 3,
  parameter int STAMP_W = 16,
  localparam int IW = $clog2(C),
  localparam int NW = $clog2(C + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit,
  input  logic [TAG_W-1:0]   tag,
  input  logic [STAMP_W-1:0] now,
  input  logic [NW-1:0]      p,
  input  logic               g_b1,
  input  logic               g_b2,
  output logic               hit,
  output logic               evict,
  output logic [TAG_W-1:0]   victim_tag,
  output logic               victim_t2
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic               v_a   [C];
  logic               f_a   [C];   // 1: frequency partition
  logic [TAG_W-1:0]   tag_a [C];
  logic [CNT_W-1:0]   cnt_a [C];
  logic [STAMP_W-1:0] st_a  [C];

  logic [IW-1:0] hidx, fidx, lidx, qidx, vidx, widx;
  logic          free_ok, lru_ok, lfu_ok, from_t1, full;
  logic [NW-1:0] n1, n2;

  always_comb begin
    hit = 1'b0; hidx = '0; fidx = '0; lidx = '0; qidx = '0;
    free_ok = 1'b0; lru_ok = 1'b0; lfu_ok = 1'b0;
    n1 = '0; n2 = '0;
    for (int i = 0; i < C; i++) begin
      if (v_a[i] && tag_a[i] == tag) begin
        hit  = 1'b1;
        hidx = IW'(i);
      end
      if (v_a[i]) begin
        if (f_a[i]) n2 = n2 + NW'(1);
        else        n1 = n1 + NW'(1);
      end
      if (!v_a[i] && !free_ok) begin
        free_ok = 1'b1;
        fidx    = IW'(i);
      end
      if (v_a[i] && !f_a[i] && (!lru_ok || st_a[i] < st_a[lidx])) begin
        lru_ok = 1'b1;
        lidx   = IW'(i);
      end
      if (v_a[i] && f_a[i] && (!lfu_ok || cnt_a[i] < cnt_a[qidx] ||
          (cnt_a[i] == cnt_a[qidx] && st_a[i] < st_a[qidx]))) begin
        lfu_ok = 1'b1;
        qidx   = IW'(i);
      end
    end
    full = !free_ok;
    if (g_b1)      from_t1 = !lfu_ok;
    else if (g_b2) from_t1 = lru_ok;
    else           from_t1 = lru_ok && ((n1 > p) || !lfu_ok);
    vidx       = from_t1 ? lidx : qidx;
    evict      = !hit && full;
    victim_tag = tag_a[vidx];
    victim_t2  = !from_t1;
    widx       = full ? vidx : fidx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < C; i++) v_a[i] <= 1'b0;
    end else if (commit) begin
      if (hit) begin
        f_a[hidx]   <= 1'b1;
        st_a[hidx]  <= now;
        cnt_a[hidx] <= !f_a[hidx] ? CNT_W'(2) :
                       (cnt_a[hidx] == CMAX) ? CMAX : cnt_a[hidx] + CNT_W'(1);
      end else begin
        v_a[widx]   <= 1'b1;
        f_a[widx]   <= g_b1 | g_b2;
        tag_a[widx] <= tag;
        st_a[widx]  <= now;
        cnt_a[widx] <= (g_b1 | g_b2) ? CNT_W'(2) : CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/arc_ghost_store.sv
module arc_ghost_store #(
  parameter int C       = 4,
  parameter int TAG_W   = 8,
  parameter int STAMP_W = 16,
  localparam int G  = 2 * C,
  localparam int GW = $clog2(G),
  localparam int NW = $clog2(C + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               commit,
  input  logic [TAG_W-1:0]   tag,
  input  logic [STAMP_W-1:0] now,
  input  logic               ins_en,
  input  logic [TAG_W-1:0]   ins_tag,
  input  logic               ins_b2,
  output logic               hit_b1,
  output logic               hit_b2
);
  logic               v_a   [G];
  logic               l_a   [G];   // 1: frequency history
  logic [TAG_W-1:0]   tag_a [G];
  logic [STAMP_W-1:0] st_a  [G];

  logic [GW-1:0] hidx, fidx, o1, o2, slot;
  logic          free_ok, ok1, ok2, same, lfull;
  logic [NW-1:0] n1, n2, nl;

  always_comb begin
    hit_b1 = 1'b0; hit_b2 = 1'b0; hidx = '0; fidx = '0; o1 = '0; o2 = '0;
    free_ok = 1'b0; ok1 = 1'b0; ok2 = 1'b0; n1 = '0; n2 = '0;
    for (int i = 0; i < G; i++) begin
      if (v_a[i] && tag_a[i] == tag) begin
        if (l_a[i]) hit_b2 = 1'b1;
        else        hit_b1 = 1'b1;
        hidx = GW'(i);
      end
      if (!v_a[i] && !free_ok) begin
        free_ok = 1'b1;
        fidx    = GW'(i);
      end
      if (v_a[i] && !l_a[i]) begin
        n1 = n1 + NW'(1);
        if (!ok1 || st_a[i] < st_a[o1]) begin ok1 = 1'b1; o1 = GW'(i); end
      end
      if (v_a[i] && l_a[i]) begin
        n2 = n2 + NW'(1);
        if (!ok2 || st_a[i] < st_a[o2]) begin ok2 = 1'b1; o2 = GW'(i); end
      end
    end
    same  = ins_b2 ? hit_b2 : hit_b1;
    nl    = (ins_b2 ? n2 : n1) - (same ? NW'(1) : NW'(0));
    lfull = (nl == NW'(C));
    if (lfull)                 slot = ins_b2 ? o2 : o1;
    else if (hit_b1 || hit_b2) slot = hidx;
    else                       slot = fidx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < G; i++) v_a[i] <= 1'b0;
    end else if (commit) begin
      if (hit_b1 || hit_b2) v_a[hidx] <= 1'b0;
      if (ins_en) begin
        v_a[slot]   <= 1'b1;
        l_a[slot]   <= ins_b2;
        tag_a[slot] <= ins_tag;
        st_a[slot]  <= now;
      end
    end
  end
endmodule

// File: rtl/arc_split.sv
module arc_split #(
  parameter int C = 4,
  localparam int NW = $clog2(C + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic          up,
  input  logic          dn,
  output logic [NW-1:0] p
);
  always_ff @(posedge clk) begin
    if (rst) p <= '0;
    else if (commit && up && p != NW'(C)) p <= p + NW'(1);
    else if (commit && dn && p != '0)     p <= p - NW'(1);
  end
endmodule

// File: rtl/arc_repl_ctrl.sv
module arc_repl_ctrl #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 8,
  parameter int CNT_W   = 3,
  parameter int STAMP_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [TAG_W-1:0]             req_tag,
  output logic                         rsp_valid,
  output logic [1:0]                   rsp_kind,
  output logic                         rsp_evict,
  output logic [TAG_W-1:0]             rsp_victim,
  output logic [$clog2(ENTRIES+1)-1:0] rsp_target
);
  import arc_pkg::*;
  localparam int NW = $clog2(ENTRIES + 1);

  logic               busy;
  logic [TAG_W-1:0]   tag_q;
  logic [STAMP_W-1:0] stamp;
  logic               r_hit, r_evict, r_vt2, g1_raw, g2_raw, gb1, gb2;
  logic [TAG_W-1:0]   r_vtag;
  logic [NW-1:0]      p;
  kind_e              kind;

  assign req_ready  = !busy;
  assign gb1        = g1_raw && !r_hit;
  assign gb2        = g2_raw && !r_hit;
  assign rsp_target = p;

  always_comb begin
    if (r_hit)    kind = K_HIT;
    else if (gb1) kind = K_GB1;
    else if (gb2) kind = K_GB2;
    else          kind = K_MISS;
  end

  arc_res_store #(.C(ENTRIES), .TAG_W(TAG_W), .CNT_W(CNT_W), .STAMP_W(STAMP_W)) u_res (
    .clk(clk), .rst(rst), .commit(busy), .tag(tag_q), .now(stamp), .p(p),
    .g_b1(gb1), .g_b2(gb2), .hit(r_hit), .evict(r_evict),
    .victim_tag(r_vtag), .victim_t2(r_vt2)
  );

  arc_ghost_store #(.C(ENTRIES), .TAG_W(TAG_W), .STAMP_W(STAMP_W)) u_ghost (
    .clk(clk), .rst(rst), .commit(busy), .tag(tag_q), .now(stamp),
    .ins_en(r_evict), .ins_tag(r_vtag), .ins_b2(r_vt2),
    .hit_b1(g1_raw), .hit_b2(g2_raw)
  );

  arc_split #(.C(ENTRIES)) u_split (
    .clk(clk), .rst(rst), .commit(busy), .up(gb1), .dn(gb2), .p(p)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      tag_q      <= '0;
      stamp      <= '0;
      rsp_valid  <= 1'b0;
      rsp_kind   <= 2'd0;
      rsp_evict  <= 1'b0;
      rsp_victim <= '0;
    end else begin
      rsp_valid <= busy;
      if (busy) begin
        busy       <= 1'b0;
        stamp      <= stamp + STAMP_W'(1);
        rsp_kind   <= kind;
        rsp_evict  <= r_evict;
        rsp_victim <= r_evict ? r_vtag : '0;
      end else if (req_valid) begin
        busy  <= 1'b1;
        tag_q <= req_tag;
      end
    end
  end
endmodule

// File: rtl/arc_repl_ctrl_chk.sv
module arc_repl_ctrl_chk #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         req_valid,
  input logic                         req_ready,
  input logic                         rsp_valid,
  input logic [1:0]                   rsp_kind,
  input logic                         rsp_evict,
  input logic [TAG_W-1:0]             rsp_victim,
  input logic [$clog2(ENTRIES+1)-1:0] rsp_target
);
  localparam int NW = $clog2(ENTRIES + 1);

  a_r1_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  a_r1_rsp_timing: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |-> ##2 rsp_valid);
  a_r1_rsp_single: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  a_r2_miss_keeps_target: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == 2'd0) |-> rsp_target == $past(rsp_target));
  a_r4_hit_quiet: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == 2'd1) |-> (!rsp_evict && rsp_target == $past(rsp_target)));
  a_r6_b1_raises: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == 2'd2) |->
      (rsp_target == $past(rsp_target) + NW'(1) ||
       ($past(rsp_target) == NW'(ENTRIES) && rsp_target == NW'(ENTRIES))));
  a_r6_target_bound: assert property (@(posedge clk) disable iff (rst)
    rsp_target <= NW'(ENTRIES));
  a_r7_b2_lowers: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == 2'd3) |->
      (rsp_target == $past(rsp_target) - NW'(1) ||
       ($past(rsp_target) == '0 && rsp_target == '0)));
endmodule

bind arc_repl_ctrl arc_repl_ctrl_chk #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_evict(rsp_evict),
  .rsp_victim(rsp_victim), .rsp_target(rsp_target)
);

// File: tb/tb_arc_repl_ctrl.sv
module tb_arc_repl_ctrl;
  localparam int C     = 4;
  localparam int TAG_W = 8;
  localparam int CMAX  = 7;

  logic             clk = 1'b0, rst = 1'b1, req_valid = 1'b0;
  logic [TAG_W-1:0] req_tag = '0;
  logic             req_ready, rsp_valid, rsp_evict;
  logic [1:0]       rsp_kind;
  logic [TAG_W-1:0] rsp_victim;
  logic [2:0]       rsp_target;

  arc_repl_ctrl #(.ENTRIES(C), .TAG_W(TAG_W), .CNT_W(3), .STAMP_W(16)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_tag(req_tag), .rsp_valid(rsp_valid), .rsp_kind(rsp_kind),
    .rsp_evict(rsp_evict), .rsp_victim(rsp_victim), .rsp_target(rsp_target)
  );

  always #4 clk = ~clk;

  int nvec = 0, nfail = 0;
  int t1[$], t2t[$], t2c[$], t2s[$], b1[$], b2[$];
  int mp = 0, now = 0;
  int e_kind, e_vic, e_ev;
  logic [15:0] lfsr = 16'hACE1;

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  task automatic model_reset();
    t1.delete(); t2t.delete(); t2c.delete(); t2s.delete();
    b1.delete(); b2.delete(); mp = 0; now = 0;
  endtask

  task automatic push_ghost(bit to_b2, int tg);
    if (to_b2) begin if (b2.size() == C) void'(b2.pop_front()); b2.push_back(tg); end
    else       begin if (b1.size() == C) void'(b1.pop_front()); b1.push_back(tg); end
  endtask

  task automatic evict_t1();
    e_ev = 1; e_vic = t1.pop_front(); push_ghost(1'b0, e_vic);
  endtask

  task automatic evict_t2();  // lowest count, older stamp on tie
    int k = 0;
    for (int i = 1; i < t2t.size(); i++)
      if (t2c[i] < t2c[k] || (t2c[i] == t2c[k] && t2s[i] < t2s[k])) k = i;
    e_ev = 1; e_vic = t2t[k];
    t2t.delete(k); t2c.delete(k); t2s.delete(k);
    push_ghost(1'b1, e_vic);
  endtask

  task automatic model(int tg);
    bit done = 0;
    bit full;
    e_ev = 0; e_vic = 0;
    full = (t1.size() + t2t.size() == C);
    foreach (t1[i]) if (!done && t1[i] == tg) begin
      t1.delete(i); t2t.push_back(tg); t2c.push_back(2); t2s.push_back(now);
      e_kind = 1; done = 1;
    end
    foreach (t2t[i]) if (!done && t2t[i] == tg) begin
      if (t2c[i] < CMAX) t2c[i]++;
      t2s[i] = now; e_kind = 1; done = 1;
    end
    foreach (b1[i]) if (!done && b1[i] == tg) begin
      b1.delete(i); e_kind = 2; done = 1;
      if (mp < C) mp++;
      if (full) begin if (t2t.size() != 0) evict_t2(); else evict_t1(); end
      t2t.push_back(tg); t2c.push_back(2); t2s.push_back(now);
    end
    foreach (b2[i]) if (!done && b2[i] == tg) begin
      b2.delete(i); e_kind = 3; done = 1;
      if (mp > 0) mp--;
      if (full) begin if (t1.size() != 0) evict_t1(); else evict_t2(); end
      t2t.push_back(tg); t2c.push_back(2); t2s.push_back(now);
    end
    if (!done) begin
      e_kind = 0;
      if (full) begin
        if (t1.size() != 0 && (t1.size() > mp || t2t.size() == 0)) evict_t1();
        else evict_t2();
      end
      t1.push_back(tg);
    end
    now++;
  endtask

  // Called at a negedge with the block idle; returns at the response negedge.
  task automatic lookup(int tg, string force_req);
    string rk, rv;
    bit vic_t2;
    int prev_b2;
    prev_b2 = b2.size();
    model(tg);
    vic_t2 = e_ev && (b2.size() != prev_b2 || (b2.size() == C && b2[C-1] == e_vic));
    case (e_kind) 0: rk = "R2"; 1: rk = "R4"; 2: rk = "R6"; default: rk = "R7"; endcase
    rv = (e_kind == 0) ? "R3" : rk;
    if (vic_t2) rv = "R5";
    if (force_req != "") begin rk = force_req; rv = force_req; end
    req_valid = 1'b1; req_tag = TAG_W'(tg);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && !rsp_valid, "R1", "busy after accept", int'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid && req_ready, "R1", "response cycle", int'(rsp_valid), 1);
    chk(int'(rsp_kind) == e_kind, rk, "kind", int'(rsp_kind), e_kind);
    chk(int'(rsp_evict) == e_ev, rv, "evict", int'(rsp_evict), e_ev);
    chk(int'(rsp_victim) == e_vic, rv, "victim", int'(rsp_victim), e_vic);
    chk(int'(rsp_target) == mp, rk, "target", int'(rsp_target), mp);
  endtask

  task automatic do_reset();
    rst = 1'b1; req_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    model_reset();
    @(negedge clk);
    // R9 reset state
    chk(req_ready == 1'b1, "R9", "ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R9", "rsp_valid", int'(rsp_valid), 0);
    chk(rsp_target == 3'd0, "R9", "target", int'(rsp_target), 0);
  endtask

  function automatic int next_tag(int range);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr) % range;
  endfunction

  initial begin
    do_reset();
    // R9: nothing remembered after reset, first lookup misses
    lookup(3, "R9");
    // R8: overflow the recency history, then probe which tags survived
    for (int t = 4; t < 12; t++) lookup(t, "");
    lookup(6, "R8");   // still in history
    lookup(6, "R8");   // removed from history, now resident
    lookup(3, "R8");   // dropped as oldest
    // R5: build unequal counts in the frequency partition, force T2 victims
    do_reset();
    for (int t = 0; t < 4; t++) lookup(t, "");
    for (int r = 0; r < 9; r++) lookup(0, "");
    for (int r = 0; r < 2; r++) lookup(1, "");
    lookup(2, ""); lookup(3, "");
    for (int t = 20; t < 26; t++) lookup(t, "");
    // R6/R7 cyclic scans larger than the store
    do_reset();
    for (int r = 0; r < 60; r++) for (int t = 0; t < 7; t++) lookup(t, "");
    // pseudo-random sweeps over several tag ranges
    for (int ph = 0; ph < 4; ph++) begin
      do_reset();
      for (int n = 0; n < 1200; n++) lookup(next_tag(5 + 2 * ph), "");
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule